// File: doc/BRIEF.md
# Multimodulus Prescaler (divide by 32, 33, 47 or 48)

This block divides a fast input clock by one of four ratios: 32, 33, 47 or 48. A modulus bit and a band bit choose the ratio. Inside there is a two-flip-flop core that divides by two or by three. It drives a chain of divide-by-two stages; with the default four stages the chain adds a fixed factor of sixteen. A feedback term that is true only when every chain stage sits in its final state decides when the core swallows, or skips, one extra input cycle. The band bit inverts that mode control. The same core and chain therefore give either the 32/33 pair or the 47/48 pair, with no extra storage.

Everything runs in the input clock domain. Each chain stage is a flip-flop with an enable and stands in for one ripple stage. The block outputs a divided clock, which is the last chain stage, and a terminal pulse that is one input cycle wide and marks the last input cycle of every output period. The two control bits are captured once per period, so every period has the full length of one ratio.

Top module: `msp_prescaler`

## Requirements
- R1: While `rst` is high at a rising edge, the next cycle shows `tc_o` = 0 and `div_clk_o` = 0.
- R2: With `band_i` = 0 and `mod_i` = 1, each output period is 32 input cycles long.
- R3: With `band_i` = 0 and `mod_i` = 0, each output period is 33 input cycles long.
- R4: With `band_i` = 1 and `mod_i` = 1, each output period is 48 input cycles long.
- R5: With `band_i` = 1 and `mod_i` = 0, each output period is 47 input cycles long.
- R6: `tc_o` is high for exactly one input cycle per output period, on the last cycle of that period.
- R7: `mod_i` and `band_i` are captured in the cycle where `tc_o` is high, and in every reset cycle. A change in the middle of a period leaves that period's length unchanged and takes effect from the next period.
- R8: The first period after reset is released has the full length selected by the inputs held during reset. It is counted from the first cycle after release up to and including the first `tc_o`.
- R9: `div_clk_o` is low for the first half of the core cycles in a period and high for the second half. The second half contains the swallow cycle. `div_clk_o` is therefore high for 16, 17, 24 and 23 input cycles in the 32, 33, 48 and 47 modes, and it is low in the cycle after `tc_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast input clock |
| rst | input | 1 | Synchronous active-high reset |
| mod_i | input | 1 | Modulus select; chooses the lower or higher ratio of the band |
| band_i | input | 1 | Band select; 0 for the 32/33 pair, 1 for the 47/48 pair |
| div_clk_o | output | 1 | Divided clock, the last chain stage |
| tc_o | output | 1 | One-cycle pulse on the last input cycle of each period |

## Verification
The hardest case to reach from the ports is a control change that arrives part way through a period. This must not produce a period of mixed length. The stimulus first locks onto a terminal pulse. It then counts a fixed number of cycles into the next period, switches both control bits, and checks that the current period keeps its old length while the following one takes the new length. A second hard case is the first period after reset, because the captured controls come from the reset cycle rather than from a terminal pulse. The bench reasserts reset with a non-default ratio and counts cycles from release to the first pulse.

// File: rtl/msp_pkg.sv
package msp_pkg;

   // Control pair captured once per output period
   typedef struct packed {
      logic band;
      logic modv;
   } msp_ctrl_t;

   // Period length in input cycles for a chain of the given depth
   function automatic int unsigned msp_ratio(input int unsigned stages,
                                             input logic band,
                                             input logic modv);
      int unsigned base;
      base = 32'd1 << stages;
      if (!band) msp_ratio = modv ? 2 * base : 2 * base + 1;
      else       msp_ratio = modv ? 3 * base : 3 * base - 1;
   endfunction

endpackage

// File: rtl/msp_core23.sv
module msp_core23 (
   input  logic clk,
   input  logic rst,
   input  logic pick_two,   // 1: two input cycles per core cycle, 0: three
   output logic cyc_end     // last input cycle of the current core cycle
);
   // Two state flip-flops step through 0,1(,2)
   logic [1:0] phase_q;

   always_comb begin
      if (pick_two) cyc_end = (phase_q == 2'd1);
      else          cyc_end = (phase_q == 2'd2);
   end

   always_ff @(posedge clk) begin
      if (rst)          phase_q <= 2'd0;
      else if (cyc_end) phase_q <= 2'd0;
      else              phase_q <= phase_q + 2'd1;
   end
endmodule

// File: rtl/msp_chain.sv
module msp_chain #(
   parameter int unsigned STAGES = 4
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              step,
   output logic [STAGES-1:0] stage_q,
   output logic              all_final
);
   // carry[i] enables stage i; it mimics the ripple edge reaching it
   logic [STAGES:0] carry;

   assign carry[0] = step;

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      assign carry[i+1] = carry[i] & stage_q[i];
      always_ff @(posedge clk) begin
         if (rst)           stage_q[i] <= 1'b0;
         else if (carry[i]) stage_q[i] <= ~stage_q[i];
      end
   end

   assign all_final = &stage_q;
endmodule

// File: rtl/msp_prescaler.sv
module msp_prescaler #(
   parameter int unsigned STAGES = 4
) (
   input  logic clk,
   input  logic rst,
   input  logic mod_i,
   input  logic band_i,
   output logic div_clk_o,
   output logic tc_o
);
   import msp_pkg::*;

   localparam int unsigned TOP_BIT = STAGES - 1;

   if (STAGES < 1 || STAGES > 12) begin : g_bad_stages
      $error("msp_prescaler: STAGES must lie in 1..12");
   end

   msp_ctrl_t         ctrl_q;
   logic              core_end;
   logic              chain_full;
   logic [STAGES-1:0] chain_q;
   logic              swallow_n;   // NAND of inverted modulus and chain term
   logic              core_two;

   // Controls held for the whole period; loaded on reset and on each pulse
   always_ff @(posedge clk) begin
      if (rst || tc_o) begin
         ctrl_q.band <= band_i;
         ctrl_q.modv <= mod_i;
      end
   end

   assign swallow_n = ~(~ctrl_q.modv & chain_full);
   assign core_two  = ctrl_q.band ? ~swallow_n : swallow_n;

   msp_core23 u_core (
      .clk      (clk),
      .rst      (rst),
      .pick_two (core_two),
      .cyc_end  (core_end)
   );

   msp_chain #(.STAGES(STAGES)) u_chain (
      .clk       (clk),
      .rst       (rst),
      .step      (core_end),
      .stage_q   (chain_q),
      .all_final (chain_full)
   );

   assign tc_o      = core_end & chain_full;
   assign div_clk_o = chain_q[TOP_BIT];
endmodule

// File: rtl/msp_prescaler_chk.sv
module msp_prescaler_chk #(
   parameter int unsigned STAGES = 4
) (
   input logic clk,
   input logic rst,
   input logic mod_i,
   input logic band_i,
   input logic div_clk_o,
   input logic tc_o
);
   import msp_pkg::*;

   logic [15:0] run_cnt;
   logic [15:0] want_len;

   always_ff @(posedge clk) begin
      if (rst || tc_o) begin
         run_cnt  <= 16'd0;
         want_len <= 16'(msp_ratio(STAGES, band_i, mod_i));
      end else begin
         run_cnt  <= run_cnt + 16'd1;
      end
   end

   // R1: reset clears both outputs
   p_reset_clear_r1: assert property (@(posedge clk)
      rst |=> (!tc_o && !div_clk_o));

   // R2..R5, R7, R8: each period matches the ratio captured at its start
   p_period_len_r7: assert property (@(posedge clk) disable iff (rst)
      tc_o |-> (run_cnt + 16'd1 == want_len));

   // R6: the terminal pulse is a single cycle
   p_tc_single_r6: assert property (@(posedge clk) disable iff (rst)
      tc_o |=> !tc_o);

   // R9: divided clock drops right after the pulse
   p_div_fall_r9: assert property (@(posedge clk) disable iff (rst)
      tc_o |=> !div_clk_o);

   // R9: divided clock never rises on a pulse cycle
   p_div_rise_r9: assert property (@(posedge clk) disable iff (rst)
      $rose(div_clk_o) |-> !tc_o);
endmodule

bind msp_prescaler msp_prescaler_chk #(.STAGES(STAGES)) u_chk (
   .clk       (clk),
   .rst       (rst),
   .mod_i     (mod_i),
   .band_i    (band_i),
   .div_clk_o (div_clk_o),
   .tc_o      (tc_o)
);

// File: tb/msp_prescaler_tb.sv
module msp_prescaler_tb;
   logic clk = 1'b0;
   logic rst = 1'b1;
   logic mod_i = 1'b1;
   logic band_i = 1'b0;
   logic div_clk_o;
   logic tc_o;

   int n_run = 0;
   int n_bad = 0;
   int cyc = 0;

   always #2 clk = ~clk;   // 4 ns period, 250 MHz

   msp_prescaler u_dut (
      .clk       (clk),
      .rst       (rst),
      .mod_i     (mod_i),
      .band_i    (band_i),
      .div_clk_o (div_clk_o),
      .tc_o      (tc_o)
   );

   localparam int NV = 7;
   localparam bit VB [NV] = '{1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0};
   localparam bit VM [NV] = '{1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1};
   localparam int VL [NV] = '{32, 33, 48, 47, 33, 48, 32};
   localparam int VH [NV] = '{16, 17, 24, 23, 17, 24, 16};
   localparam string VR [NV] = '{"R2", "R3", "R4", "R5", "R3", "R4", "R2"};

   task automatic check(input string req, input int act, input int exp);
      n_run++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: got %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic wait_tc();
      @(negedge clk);
      while (!tc_o) @(negedge clk);
   endtask

   // Count one period from the cycle after a pulse up to the next pulse
   task automatic measure(output int len, output int hi);
      len = 0;
      hi  = 0;
      do begin
         @(negedge clk);
         len++;
         if (div_clk_o) hi++;
      end while (!tc_o && len < 200);
   endtask

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > 50000) begin
         n_bad++;
         n_run++;
         $display("FAIL watchdog: got %0d expected %0d", cyc, 50000);
         $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
         $finish;
      end
   end

   initial begin
      int len;
      int hi;
      // R1: outputs during reset
      repeat (3) @(negedge clk);
      check("R1 tc in reset", int'(tc_o), 0);
      check("R1 div in reset", int'(div_clk_o), 0);
      rst = 1'b0;

      // Table walk: change controls, finish the running period, then measure
      for (int v = 0; v < NV; v++) begin
         band_i = VB[v];
         mod_i  = VM[v];
         wait_tc();
         measure(len, hi);
         check(VR[v], len, VL[v]);
         check({VR[v], " R9 high"}, hi, VH[v]);
         @(negedge clk);
         check("R6 single pulse", int'(tc_o), 0);
         check("R9 low after pulse", int'(div_clk_o), 0);
      end

      // R7: change mid-period, old length kept, new length next
      band_i = 1'b0;
      mod_i  = 1'b1;
      wait_tc();
      measure(len, hi);
      check("R7 settle", len, 32);
      len = 0;
      for (int k = 0; k < 10; k++) begin
         @(negedge clk);
         len++;
      end
      band_i = 1'b1;
      mod_i  = 1'b1;
      while (!tc_o) begin
         @(negedge clk);
         len++;
      end
      check("R7 current period kept", len, 32);
      measure(len, hi);
      check("R7 next period new", len, 48);

      // R8: reset with a 47 setting, first period full length
      @(negedge clk);
      rst    = 1'b1;
      band_i = 1'b1;
      mod_i  = 1'b0;
      @(negedge clk);
      @(negedge clk);
      check("R1 tc after reset", int'(tc_o), 0);
      check("R1 div after reset", int'(div_clk_o), 0);
      rst = 1'b0;
      len = 1;
      while (!tc_o && len < 200) begin
         @(negedge clk);
         len++;
      end
      check("R8 first period", len, 47);
      measure(len, hi);
      check("R5 after reset", len, 47);

      $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
      $finish;
   end
endmodule